// File: doc/BRIEF.md
# Cascaded Reset Tree Controller

This block turns one root power-on reset into a chain of active-low reset trees: a life-cycle tree, a system tree below it, and a set of per-module resets below that. A reset taken at any level pulls down every level beneath it. Peripheral reset requests (watchdog, escalation and similar) and a power-manager request pull down the life-cycle tree. The debug non-debug-module request and a second power-manager request pull down only the system tree and the modules.

Each tree is copied once per power domain. Domain 0 is always on. Every other domain has an "on" input, and while it is low that domain's whole chain is held in reset, with no effect on any other domain. Software may hold a module's reset through a small control register. The system reset clears that register. The always-on copies of the life-cycle and system trees are reported back to the power manager.

Every reset output asserts asynchronously. It deasserts through a two-flop synchronizer on the block clock, so an output rises on the second rising edge after its last cause goes away.

Top module: `reset_cascade_ctrl`

## Requirements
- R1: While `porN` is low, every reset output is 0 and `swCtrlQ` is 0. The outputs fall at once when `porN` falls, with no clock edge needed.
- R2: Any bit of `periphReq`, or `pwrLcReq`, at 1 drives `rstLcN`, `rstSysN` and `rstModN` to 0 in every domain.
- R3: `ndmReq` or `pwrSysReq` at 1 drives `rstSysN` and `rstModN` to 0 in every domain. `rstLcN` stays 1.
- R4: The trees cascade within each domain. `rstLcN[d]`=0 implies `rstSysN[d]`=0, and `rstSysN[d]`=0 implies every `rstModN[d*NUM_MODULES+m]`=0.
- R5: `domainOn[i]`=0 drives all resets of domain i+1 to 0. Domain 0 has no on input. The resets of every other domain are unchanged.
- R6: `swCtrlQ[m]`=1 holds `rstModN[d*NUM_MODULES+m]` at 0 in every domain. Other modules, `rstLcN` and `rstSysN` are unaffected.
- R7: A pulse on `swWrEn` loads `swWrData` into `swCtrlQ` at the clock edge, but only while `rstSysN[0]` is 1. `swCtrlQ` is cleared whenever `rstSysN[0]` is 0, and writes made then are ignored.
- R8: A reset output rises on the second rising clock edge after its last cause is removed. After the first edge it is still 0.
- R9: `lcStateN` equals `rstLcN[0]` and `sysStateN` equals `rstSysN[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all deassertion synchronizers and the control register |
| porN | input | 1 | Root power-on reset, active low, asynchronous |
| periphReq | input | NUM_PERIPH | Peripheral reset requests, active high |
| pwrLcReq | input | 1 | Power-manager request for the life-cycle tree |
| ndmReq | input | 1 | Debug non-debug-module reset request |
| pwrSysReq | input | 1 | Power-manager request for the system tree |
| domainOn | input | NUM_DOMAINS-1 | Bit i high when domain i+1 is powered |
| swWrEn | input | 1 | Write strobe for the software module-reset register |
| swWrData | input | NUM_MODULES | Value written into the software module-reset register |
| rstLcN | output | NUM_DOMAINS | Life-cycle reset per domain |
| rstSysN | output | NUM_DOMAINS | System reset per domain |
| rstModN | output | NUM_DOMAINS*NUM_MODULES | Module resets, index d*NUM_MODULES+m |
| lcStateN | output | 1 | Life-cycle tree state to the power manager |
| sysStateN | output | 1 | System tree state to the power manager |
| swCtrlQ | output | NUM_MODULES | Current software module-reset register |

## Verification
The hardest case to reach is the control register losing its value because of a system reset, and a write landing while that reset is still held. Both involve an internal clear tied to a synchronized reset. The stimulus loads a module bit and shows its reset held. It then raises the debug request for a few cycles and reads back a cleared register and released module resets. A write issued during a held debug request must leave the register at zero once the reset lifts. Release timing is checked on the first and second edges after every cause is removed, including an asynchronous power-on drop made between clock edges.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
package rcc_pkg;
  // Strobes from control to the synchronizer datapath (1 = hold in reset)
  typedef struct packed {
    logic lcHold;
    logic sysHold;
  } treeStrobe_t;
endpackage

// File: rtl/rcc_sync_cell.sv
`timescale 1ns/1ps
module rcc_sync_cell #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clrN,
  output logic rstOutN
);
  logic [STAGES-1:0] stages;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) stages <= '0;
    else       stages <= {stages[STAGES-2:0], 1'b1};
  end

  assign rstOutN = stages[STAGES-1];
endmodule

// File: rtl/rcc_ctrl.sv
`timescale 1ns/1ps
module rcc_ctrl
  import rcc_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int NUM_MODULES = 2,
  parameter int NUM_PERIPH  = 3
) (
  input  logic                   clk,
  input  logic                   porN,
  input  logic [NUM_PERIPH-1:0]  periphReq,
  input  logic                   pwrLcReq,
  input  logic                   ndmReq,
  input  logic                   pwrSysReq,
  input  logic [NUM_DOMAINS-2:0] domainOn,
  input  logic                   swWrEn,
  input  logic [NUM_MODULES-1:0] swWrData,
  input  logic                   sysLeafN,
  output treeStrobe_t            strobe,
  output logic [NUM_DOMAINS-1:0] domOff,
  output logic [NUM_MODULES-1:0] modHold,
  output logic [NUM_MODULES-1:0] swCtrlQ
);
  logic lcCause;
  logic sysCause;

  // Cascade: life-cycle from root and peripherals, system adds debug causes
  always_comb begin
    lcCause  = !porN || (|periphReq) || pwrLcReq;
    sysCause = lcCause || ndmReq || pwrSysReq;
  end

  assign strobe.lcHold  = lcCause;
  assign strobe.sysHold = sysCause;

  // Domain 0 is always on; others are forced off by their enable
  assign domOff[0] = 1'b0;
  for (genvar d = 1; d < NUM_DOMAINS; d++) begin : gDomOff
    assign domOff[d] = !domainOn[d-1];
  end

  // Software hold register, cleared by the always-on system reset
  always_ff @(posedge clk or negedge sysLeafN) begin
    if (!sysLeafN)   swCtrlQ <= '0;
    else if (swWrEn) swCtrlQ <= swWrData;
  end

  for (genvar m = 0; m < NUM_MODULES; m++) begin : gModHold
    assign modHold[m] = sysCause || swCtrlQ[m];
  end
endmodule

// File: rtl/rcc_datapath.sv
`timescale 1ns/1ps
module rcc_datapath
  import rcc_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int NUM_MODULES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  treeStrobe_t                        strobe,
  input  logic [NUM_DOMAINS-1:0]             domOff,
  input  logic [NUM_MODULES-1:0]             modHold,
  output logic [NUM_DOMAINS-1:0]             rstLcN,
  output logic [NUM_DOMAINS-1:0]             rstSysN,
  output logic [NUM_DOMAINS*NUM_MODULES-1:0] rstModN
);
  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : gDom
    logic lcClrN;
    logic sysClrN;
    assign lcClrN  = !(strobe.lcHold  || domOff[d]);
    assign sysClrN = !(strobe.sysHold || domOff[d]);

    rcc_sync_cell #(.STAGES(SYNC_STAGES)) uLc (
      .clk(clk), .clrN(lcClrN), .rstOutN(rstLcN[d]));
    rcc_sync_cell #(.STAGES(SYNC_STAGES)) uSys (
      .clk(clk), .clrN(sysClrN), .rstOutN(rstSysN[d]));

    for (genvar m = 0; m < NUM_MODULES; m++) begin : gMod
      logic modClrN;
      assign modClrN = !(modHold[m] || domOff[d]);
      rcc_sync_cell #(.STAGES(SYNC_STAGES)) uMod (
        .clk(clk), .clrN(modClrN), .rstOutN(rstModN[d*NUM_MODULES+m]));
    end
  end
endmodule

// File: rtl/reset_cascade_ctrl.sv
`timescale 1ns/1ps
module reset_cascade_ctrl
  import rcc_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int NUM_MODULES = 2,
  parameter int NUM_PERIPH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               porN,
  input  logic [NUM_PERIPH-1:0]              periphReq,
  input  logic                               pwrLcReq,
  input  logic                               ndmReq,
  input  logic                               pwrSysReq,
  input  logic [NUM_DOMAINS-2:0]             domainOn,
  input  logic                               swWrEn,
  input  logic [NUM_MODULES-1:0]             swWrData,
  output logic [NUM_DOMAINS-1:0]             rstLcN,
  output logic [NUM_DOMAINS-1:0]             rstSysN,
  output logic [NUM_DOMAINS*NUM_MODULES-1:0] rstModN,
  output logic                               lcStateN,
  output logic                               sysStateN,
  output logic [NUM_MODULES-1:0]             swCtrlQ
);
  treeStrobe_t            strobe;
  logic [NUM_DOMAINS-1:0] domOff;
  logic [NUM_MODULES-1:0] modHold;

  rcc_ctrl #(
    .NUM_DOMAINS(NUM_DOMAINS), .NUM_MODULES(NUM_MODULES), .NUM_PERIPH(NUM_PERIPH)
  ) uCtrl (
    .clk(clk), .porN(porN), .periphReq(periphReq), .pwrLcReq(pwrLcReq),
    .ndmReq(ndmReq), .pwrSysReq(pwrSysReq), .domainOn(domainOn),
    .swWrEn(swWrEn), .swWrData(swWrData), .sysLeafN(rstSysN[0]),
    .strobe(strobe), .domOff(domOff), .modHold(modHold), .swCtrlQ(swCtrlQ)
  );

  rcc_datapath #(
    .NUM_DOMAINS(NUM_DOMAINS), .NUM_MODULES(NUM_MODULES), .SYNC_STAGES(SYNC_STAGES)
  ) uPath (
    .clk(clk), .strobe(strobe), .domOff(domOff), .modHold(modHold),
    .rstLcN(rstLcN), .rstSysN(rstSysN), .rstModN(rstModN)
  );

  // Always-on tree state reported to the power manager
  assign lcStateN  = rstLcN[0];
  assign sysStateN = rstSysN[0];
endmodule

// File: rtl/rcc_checker.sv
`timescale 1ns/1ps
module rcc_checker #(
  parameter int NUM_DOMAINS = 3,
  parameter int NUM_MODULES = 2,
  parameter int NUM_PERIPH  = 3
) (
  input logic                               clk,
  input logic                               porN,
  input logic [NUM_PERIPH-1:0]              periphReq,
  input logic                               pwrLcReq,
  input logic                               ndmReq,
  input logic                               pwrSysReq,
  input logic [NUM_DOMAINS-2:0]             domainOn,
  input logic [NUM_DOMAINS-1:0]             rstLcN,
  input logic [NUM_DOMAINS-1:0]             rstSysN,
  input logic [NUM_DOMAINS*NUM_MODULES-1:0] rstModN,
  input logic [NUM_MODULES-1:0]             swCtrlQ
);
  // R2
  lc_req_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    ((|periphReq) || pwrLcReq) |-> (rstLcN == '0 && rstSysN == '0));

  // R3
  sys_req_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (ndmReq || pwrSysReq) |-> (rstSysN == '0 && rstModN == '0));

  // R7
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    !rstSysN[0] |-> (swCtrlQ == '0));

  // R8
  lc_release_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(rstLcN[0]) |-> $past(porN && !(|periphReq) && !pwrLcReq));

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : gDomChk
    // R4
    cascade_lc_sys_chk: assert property (@(posedge clk) disable iff (!porN)
      !rstLcN[d] |-> !rstSysN[d]);
    if (d > 0) begin : gOff
      // R5
      dom_off_chk: assert property (@(posedge clk) disable iff (!porN)
        !domainOn[d-1] |-> (!rstLcN[d] && !rstSysN[d]));
    end
    for (genvar m = 0; m < NUM_MODULES; m++) begin : gModChk
      // R4
      cascade_sys_mod_chk: assert property (@(posedge clk) disable iff (!porN)
        !rstSysN[d] |-> !rstModN[d*NUM_MODULES+m]);
      // R6
      sw_hold_chk: assert property (@(posedge clk) disable iff (!porN)
        swCtrlQ[m] |-> !rstModN[d*NUM_MODULES+m]);
    end
  end
endmodule

bind reset_cascade_ctrl rcc_checker #(
  .NUM_DOMAINS(NUM_DOMAINS), .NUM_MODULES(NUM_MODULES), .NUM_PERIPH(NUM_PERIPH)
) uChk (.*);

// File: tb/tb_reset_cascade_ctrl.sv
`timescale 1ns/1ps
module tb_reset_cascade_ctrl;
  localparam int ND = 3;
  localparam int NM = 2;
  localparam int NP = 3;

  typedef struct packed {
    logic          stLc;
    logic          stSys;
    logic [NM-1:0] ctrl;
    logic [ND*NM-1:0] mod;
    logic [ND-1:0] sys;
    logic [ND-1:0] lc;
  } exp_t;

  logic clk = 1'b0;
  logic porN;
  logic [NP-1:0] periphReq;
  logic pwrLcReq, ndmReq, pwrSysReq;
  logic [ND-2:0] domainOn;
  logic swWrEn;
  logic [NM-1:0] swWrData;
  logic [ND-1:0] rstLcN, rstSysN;
  logic [ND*NM-1:0] rstModN;
  logic lcStateN, sysStateN;
  logic [NM-1:0] swCtrlQ;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [NM-1:0] expCtrl;
  exp_t  expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  reset_cascade_ctrl #(.NUM_DOMAINS(ND), .NUM_MODULES(NM), .NUM_PERIPH(NP)) dut (
    .clk(clk), .porN(porN), .periphReq(periphReq), .pwrLcReq(pwrLcReq),
    .ndmReq(ndmReq), .pwrSysReq(pwrSysReq), .domainOn(domainOn),
    .swWrEn(swWrEn), .swWrData(swWrData), .rstLcN(rstLcN), .rstSysN(rstSysN),
    .rstModN(rstModN), .lcStateN(lcStateN), .sysStateN(sysStateN), .swCtrlQ(swCtrlQ));

  // Steady-state expectation from the requirements
  function automatic exp_t model(logic [NM-1:0] ctrl);
    exp_t e;
    logic lcA, sysA, off;
    lcA  = !porN || (|periphReq) || pwrLcReq;
    sysA = lcA || ndmReq || pwrSysReq;
    for (int d = 0; d < ND; d++) begin
      off = (d != 0) && !domainOn[d-1];
      e.lc[d]  = !(lcA || off);
      e.sys[d] = !(sysA || off);
      for (int m = 0; m < NM; m++)
        e.mod[d*NM+m] = !(sysA || off || ctrl[m]);
    end
    e.ctrl  = ctrl;
    e.stLc  = e.lc[0];
    e.stSys = e.sys[0];
    return e;
  endfunction

  function automatic logic sysCauseNow();
    return !porN || (|periphReq) || pwrLcReq || ndmReq || pwrSysReq;
  endfunction

  task automatic cmp(string tag, exp_t e);
    exp_t act;
    act = {lcStateN, sysStateN, swCtrlQ, rstModN, rstSysN, rstLcN};
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  task automatic push(string tag, exp_t e);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (expQ.size() > 0) cmp(tagQ.pop_front(), expQ.pop_front());
  end

  // Steady check, then return to the drive phase
  task automatic observe(string tag);
    @(posedge clk); #1;
    push(tag, model(expCtrl));
    @(negedge clk); #1;
  endtask

  // After inputs change: first edge keeps releases low, second edge frees them
  task automatic transition(string tag, exp_t old);
    exp_t nw;
    if (sysCauseNow()) expCtrl = '0;
    nw = model(expCtrl);
    @(posedge clk); #1;
    push({tag, " edge1"}, old & nw);
    @(posedge clk); #1;
    push({tag, " edge2"}, nw);
    @(negedge clk); #1;
  endtask

  task automatic swWrite(string tag, logic [NM-1:0] val);
    exp_t old, nw, mid;
    old = model(expCtrl);
    swWrEn = 1'b1; swWrData = val;
    @(posedge clk); #1;
    swWrEn = 1'b0;
    if (old.sys[0]) expCtrl = val;
    nw = model(expCtrl);
    mid = old & nw;
    mid.ctrl = nw.ctrl;
    push({tag, " edge0"}, mid);
    @(posedge clk); #1;
    push({tag, " edge1"}, mid);
    @(posedge clk); #1;
    push({tag, " edge2"}, nw);
    @(negedge clk); #1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    exp_t old;
    porN = 1'b0; periphReq = '0; pwrLcReq = 1'b0; ndmReq = 1'b0; pwrSysReq = 1'b0;
    domainOn = '1; swWrEn = 1'b0; swWrData = '0; expCtrl = '0;
    @(negedge clk); #1;
    observe("R1 held by power-on");

    old = model(expCtrl); porN = 1'b1; transition("R1 R8 power-on release", old);
    observe("R9 idle all released");

    old = model(expCtrl); periphReq = 3'b010; transition("R2 peripheral request", old);
    observe("R2 R4 peripheral held");
    old = model(expCtrl); periphReq = '0; transition("R8 peripheral release", old);

    old = model(expCtrl); pwrLcReq = 1'b1; transition("R2 power lc request", old);
    old = model(expCtrl); pwrLcReq = 1'b0; transition("R8 power lc release", old);

    old = model(expCtrl); ndmReq = 1'b1; transition("R3 debug request", old);
    observe("R3 R9 debug held lc stays high");
    old = model(expCtrl); ndmReq = 1'b0; transition("R8 debug release", old);

    old = model(expCtrl); pwrSysReq = 1'b1; transition("R3 power sys request", old);
    old = model(expCtrl); pwrSysReq = 1'b0; transition("R8 power sys release", old);

    old = model(expCtrl); domainOn = 2'b10; transition("R5 domain1 off", old);
    old = model(expCtrl); domainOn = 2'b01; transition("R5 domain2 off domain1 on", old);
    old = model(expCtrl); domainOn = 2'b11; transition("R5 all domains on", old);

    swWrite("R6 software hold module1", 2'b10);
    observe("R6 module1 held others free");
    swWrite("R6 software release", 2'b00);

    swWrite("R7 load module0", 2'b01);
    old = model(expCtrl); ndmReq = 1'b1; transition("R7 system reset clears register", old);
    swWrite("R7 write during system reset ignored", 2'b11);
    old = model(expCtrl); ndmReq = 1'b0; transition("R7 register still clear after release", old);
    observe("R7 modules free after clear");

    swWrite("R6 hold with domain off", 2'b01);
    old = model(expCtrl); domainOn = 2'b10; transition("R5 R6 domain1 off with hold", old);
    old = model(expCtrl); domainOn = 2'b11; transition("R5 domain1 back", old);
    swWrite("R6 clear", 2'b00);

    // Asynchronous drop between edges
    porN = 1'b0; expCtrl = '0;
    #2;
    cmp("R1 asynchronous power-on assertion", model(expCtrl));
    @(negedge clk); #1;
    old = model(expCtrl); porN = 1'b1; transition("R1 R8 second power-on release", old);

    repeat (2) @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule